// File: doc/BRIEF.md
# Compare Match Interval Timer

This block is one timer channel for a peripheral subsystem. A 16-bit up-counter advances on a count enable taken from a free-running divider of the peripheral clock. A 2-bit field picks a divide ratio of 4, 8, 16 or 64. Counting happens only while a run bit is set. When the count equals a programmable constant on an active count enable, the counter returns to zero and a sticky match flag is raised. Software clears the flag by writing a zero to it, and an enable bit routes the flag onto a level interrupt line.

Software reaches the channel through a small synchronous register bus with four word addresses. Read data is combinational from the address. The divider never produces a derived clock: it emits one-cycle enable pulses, and every register in the design shares the peripheral clock.

Top module: `mit_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the constant reads 0xFFFF, the control word reads 0x0000, the run word reads 0 and irq is 0.
- R2: The select field picks the count enable rate: 0 = every 4th clock, 1 = every 8th, 2 = every 16th, 3 = every 64th, timed by a divider that runs freely from reset.
- R3: The counter advances only on count enables while the run bit is 1. Clearing the run bit holds the current value, and setting it again continues from that value.
- R4: On a count enable where the counter equals the constant, the counter becomes 0x0000 and the match flag becomes 1, so the match period is constant+1 count enables.
- R5: Writing the control word with bit 7 = 0 clears the match flag. Writing bit 7 = 1 leaves the flag unchanged.
- R6: When a flag-clearing write and a match fall in the same cycle, the flag ends at 1.
- R7: A bus write to the counter loads the written value, overriding both the increment and the match clear in that cycle, and no match is recorded in that cycle.
- R8: irq is high exactly while the match flag is 1 and the interrupt enable bit (control bit 6) is 1.
- R9: Register map by bus_addr: 0 = control (bit 7 match flag, bit 6 interrupt enable, bits 1:0 select, other bits read 0), 1 = counter, 2 = constant, 3 = run word (bit 0 run, other bits read 0). A write occurs when bus_sel and bus_we are both 1.
- R10: When the counter is above the constant, it counts on through 0xFFFF and wraps to 0x0000 without setting the match flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can fall in the same cycle: a compare match, and a bus write that also acts on the same state. The write may clear the flag, or it may load the counter. The bench runs a copy of the divider phase with the constant held at a value that the counter is sitting on. It waits for the cycle where a count enable and equality coincide and issues the write on that exact edge. After the edge it reads the flag and counter back: the flag must stay set when the write cleared it, and the counter must hold the written value with no flag when the write loaded it.

// File: rtl/mit_pkg.sv
package mit_pkg;

    // Register word addresses
    localparam logic [1:0] ADR_CTRL  = 2'd0;
    localparam logic [1:0] ADR_COUNT = 2'd1;
    localparam logic [1:0] ADR_CONST = 2'd2;
    localparam logic [1:0] ADR_RUN   = 2'd3;

    // Control word field positions
    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int SEL_LSB  = 0;

    typedef enum logic [1:0] {
        DIV_BY_4  = 2'd0,
        DIV_BY_8  = 2'd1,
        DIV_BY_16 = 2'd2,
        DIV_BY_64 = 2'd3
    } div_sel_e;

    localparam int NUM_DIV = 4;

    // log2 of the divide ratio for each select code
    function automatic int div_log2(input int code);
        case (code)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            default: return 6;
        endcase
    endfunction

    localparam int PRE_W = div_log2(NUM_DIV - 1);

endpackage

// File: rtl/mit_prescaler.sv
module mit_prescaler
    import mit_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  div_sel_e sel,
    output logic     tick
);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t state_d, state_q;
    logic [NUM_DIV-1:0] tap;

    // One tap per ratio: high when the low bits of the phase are all ones
    for (genvar i = 0; i < NUM_DIV; i++) begin : g_tap
        localparam int SH = div_log2(i);
        assign tap[i] = &state_q.phase[SH-1:0];
    end

    always_comb begin
        state_d       = state_q;
        state_d.phase = state_q.phase + 1'b1;
        tick          = tap[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/mit_core.sv
module mit_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wr_value,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             match_evt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } core_state_t;

    core_state_t state_d, state_q;
    logic        step;
    logic        equal;

    always_comb begin
        state_d   = state_q;
        step      = run && tick;
        equal     = (state_q.cnt == limit);
        match_evt = step && equal && !cnt_wr;

        // Counter: bus load beats match clear beats increment
        if (cnt_wr) begin
            state_d.cnt = wr_value;
        end else if (step) begin
            if (equal) begin
                state_d.cnt = '0;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end

        // Flag: the set is applied last so it wins a collision
        if (flag_clr) begin
            state_d.flag = 1'b0;
        end
        if (match_evt) begin
            state_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count = state_q.cnt;
    assign flag  = state_q.flag;

endmodule

// File: rtl/mit_regs.sv
module mit_regs
    import mit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0] count,
    input  logic             flag,
    output div_sel_e         sel,
    output logic             ie,
    output logic             run,
    output logic [CNT_W-1:0] limit,
    output logic             cnt_wr,
    output logic             flag_clr
);

    typedef struct packed {
        logic             ie;
        div_sel_e         sel;
        logic             run;
        logic [CNT_W-1:0] limit;
    } reg_state_t;

    reg_state_t state_d, state_q;
    logic       wr;

    always_comb begin
        state_d  = state_q;
        wr       = bus_sel && bus_we;
        cnt_wr   = wr && (bus_addr == ADR_COUNT);
        flag_clr = wr && (bus_addr == ADR_CTRL) && !bus_wdata[FLAG_BIT];

        if (wr) begin
            case (bus_addr)
                ADR_CTRL: begin
                    state_d.ie  = bus_wdata[IE_BIT];
                    state_d.sel = div_sel_e'(bus_wdata[SEL_LSB +: 2]);
                end
                ADR_CONST: state_d.limit = bus_wdata;
                ADR_RUN:   state_d.run   = bus_wdata[0];
                default:   ;
            endcase
        end

        bus_rdata = '0;
        case (bus_addr)
            ADR_CTRL: begin
                bus_rdata[FLAG_BIT]       = flag;
                bus_rdata[IE_BIT]         = state_q.ie;
                bus_rdata[SEL_LSB +: 2]   = state_q.sel;
            end
            ADR_COUNT: bus_rdata    = count;
            ADR_CONST: bus_rdata    = state_q.limit;
            default:   bus_rdata[0] = state_q.run;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ie    <= 1'b0;
            state_q.sel   <= DIV_BY_4;
            state_q.run   <= 1'b0;
            state_q.limit <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign sel   = state_q.sel;
    assign ie    = state_q.ie;
    assign run   = state_q.run;
    assign limit = state_q.limit;

endmodule

// File: rtl/mit_timer.sv
module mit_timer
    import mit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);

    div_sel_e         sel;
    logic             tick;
    logic             ie_q;
    logic             start_q;
    logic [CNT_W-1:0] limit;
    logic             cnt_wr;
    logic             flag_clr;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             match_evt;

    mit_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .tick  (tick)
    );

    mit_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (cnt_q),
        .flag      (flag_q),
        .sel       (sel),
        .ie        (ie_q),
        .run       (start_q),
        .limit     (limit),
        .cnt_wr    (cnt_wr),
        .flag_clr  (flag_clr)
    );

    mit_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (start_q),
        .limit     (limit),
        .cnt_wr    (cnt_wr),
        .wr_value  (bus_wdata),
        .flag_clr  (flag_clr),
        .count     (cnt_q),
        .flag      (flag_q),
        .match_evt (match_evt)
    );

    assign irq = flag_q && ie_q;

endmodule

// File: rtl/mit_checker.sv
module mit_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             irq,
    input logic [CNT_W-1:0] cnt_q,
    input logic             flag_q,
    input logic             ie_q,
    input logic             start_q,
    input logic             tick,
    input logic             match_evt,
    input logic             cnt_wr,
    input logic             flag_clr
);

    logic ctrl_wr_one;
    assign ctrl_wr_one = bus_sel && bus_we && (bus_addr == 2'd0) && bus_wdata[7];

    // R2: the fastest ratio is 4, so enables never fall on adjacent cycles
    a_r2_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R3: a stopped counter holds unless the bus loads it
    a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_q && !cnt_wr) |=> $stable(cnt_q));

    // R4: a match returns the counter to zero and raises the flag
    a_r4_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> (cnt_q == '0) && flag_q);

    // R5: writing a one to the flag position does not set it
    a_r5_one_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_one && !flag_q && !match_evt) |=> !flag_q);

    // R6: set wins over clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && match_evt) |=> flag_q);

    // R7: a bus load of the counter takes effect whatever else happens
    a_r7_load_priority: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(bus_wdata));

    // R8: no interrupt without the flag, and an enabled flag raises it
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_q |-> !irq);
    a_r8_irq_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && ie_q) |-> irq);

endmodule

bind mit_timer mit_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .cnt_q     (cnt_q),
    .flag_q    (flag_q),
    .ie_q      (ie_q),
    .start_q   (start_q),
    .tick      (tick),
    .match_evt (match_evt),
    .cnt_wr    (cnt_wr),
    .flag_clr  (flag_clr)
);

// File: tb/tb_mit_timer.sv
`timescale 1ns/1ps
module tb_mit_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_sel = 1'b0;
    logic        b_we = 1'b0;
    logic [1:0]  b_addr = 2'd0;
    logic [15:0] b_wdata = 16'd0;
    logic [15:0] b_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    mit_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (b_sel),
        .bus_we    (b_we),
        .bus_addr  (b_addr),
        .bus_wdata (b_wdata),
        .bus_rdata (b_rdata),
        .irq       (irq)
    );

    // ---------------- reference model from the requirements ----------------
    logic [5:0]  m_pc;
    logic [15:0] m_cnt, m_cor;
    logic        m_flag, m_ie, m_start;
    logic [1:0]  m_sel;

    function automatic bit tick_fn(input logic [5:0] pc, input logic [1:0] s);
        case (s)
            2'd0:    return pc[1:0] == 2'b11;
            2'd1:    return pc[2:0] == 3'b111;
            2'd2:    return pc[3:0] == 4'hF;
            default: return pc == 6'h3F;
        endcase
    endfunction

    function automatic bit match_now();
        return m_start && tick_fn(m_pc, m_sel) && (m_cnt == m_cor);
    endfunction

    function automatic logic [15:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {8'd0, m_flag, m_ie, 4'd0, m_sel};
            2'd1:    return m_cnt;
            2'd2:    return m_cor;
            default: return {15'd0, m_start};
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pc <= '0; m_cnt <= '0; m_cor <= 16'hFFFF;
            m_flag <= 1'b0; m_ie <= 1'b0; m_start <= 1'b0; m_sel <= 2'd0;
        end else begin
            automatic bit wr = b_sel && b_we;
            automatic bit step = m_start && tick_fn(m_pc, m_sel);
            automatic bit hit = step && (m_cnt == m_cor) && !(wr && b_addr == 2'd1);
            m_pc <= m_pc + 1'b1;
            if (wr && b_addr == 2'd1) m_cnt <= b_wdata;
            else if (step) m_cnt <= (m_cnt == m_cor) ? 16'd0 : m_cnt + 1'b1;
            if (hit) m_flag <= 1'b1;
            else if (wr && b_addr == 2'd0 && !b_wdata[7]) m_flag <= 1'b0;
            if (wr && b_addr == 2'd0) begin m_ie <= b_wdata[6]; m_sel <= b_wdata[1:0]; end
            if (wr && b_addr == 2'd2) m_cor <= b_wdata;
            if (wr && b_addr == 2'd3) m_start <= b_wdata[0];
        end
    end

    // ---------------- bench tasks ----------------
    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        b_sel = 1'b1; b_we = 1'b1; b_addr = a; b_wdata = d;
        @(posedge clk);
        #1 b_sel = 1'b0; b_we = 1'b0;
    endtask

    // read at a negedge; compares against a literal expectation
    task automatic rd_exp(input string tag, input logic [1:0] a, input logic [15:0] exp);
        @(negedge clk);
        b_addr = a;
        #1 check(tag, b_rdata, exp);
    endtask

    task automatic rd_model(input string tag, input logic [1:0] a);
        @(negedge clk);
        b_addr = a;
        #1 check(tag, b_rdata, exp_read(a));
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 4; a++) rd_model(tag, 2'(a));
        check({tag, " R8 irq"}, {15'd0, irq}, {15'd0, m_flag & m_ie});
    endtask

    // drive a write on the first cycle where a match is about to happen
    task automatic wr_on_match(input logic [1:0] a, input logic [15:0] d);
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (match_now()) begin
                b_sel = 1'b1; b_we = 1'b1; b_addr = a; b_wdata = d;
                @(posedge clk);
                #1 b_sel = 1'b0; b_we = 1'b0;
                return;
            end
        end
        check("match never reached", 16'd0, 16'd1);
    endtask

    // ---------------- stimulus ----------------
    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd_exp("R1 control", 2'd0, 16'h0000);
        rd_exp("R1 counter", 2'd1, 16'h0000);
        rd_exp("R1 constant", 2'd2, 16'hFFFF);
        rd_exp("R1 run", 2'd3, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'd0);

        // R2 each ratio: 256 enabled edges give 256/N counts
        for (int s = 0; s < 4; s++) begin
            automatic int ratio = (s == 3) ? 64 : (4 << s);
            wr(2'd3, 16'd0);
            wr(2'd1, 16'd0);
            wr(2'd0, 16'(s));
            wr(2'd3, 16'd1);
            repeat (255) @(posedge clk);
            wr(2'd3, 16'd0);
            rd_exp("R2 ratio count", 2'd1, 16'(256 / ratio));
        end

        // R3 freeze and resume
        rd_exp("R3 frozen before", 2'd1, 16'd4);
        repeat (300) @(posedge clk);
        rd_exp("R3 frozen after wait", 2'd1, 16'd4);
        wr(2'd0, 16'd0);   // divide by 4
        wr(2'd3, 16'd1);
        repeat (7) @(posedge clk);
        wr(2'd3, 16'd0);   // 8 enabled edges -> 2 counts
        rd_exp("R3 resumed from held value", 2'd1, 16'd6);

        // R4 match period: constant 2, divide by 4, 12 edges -> 3 counts wraps to 0
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd2);
        wr(2'd3, 16'd1);
        repeat (11) @(posedge clk);
        wr(2'd3, 16'd0);
        rd_exp("R4 counter cleared on match", 2'd1, 16'd0);
        rd_exp("R4 flag set", 2'd0, 16'h0080);

        // R8 irq with enable
        check("R8 irq low while disabled", {15'd0, irq}, 16'd0);
        wr(2'd0, 16'h00C0);  // enable, bit7=1 keeps flag
        #1 check("R8 irq high", {15'd0, irq}, 16'd1);
        // R5 write one keeps, write zero clears
        rd_exp("R5 write one keeps flag", 2'd0, 16'h00C0);
        wr(2'd0, 16'h0040);
        rd_exp("R5 write zero clears", 2'd0, 16'h0040);
        check("R8 irq drops with flag", {15'd0, irq}, 16'd0);
        wr(2'd0, 16'h00C0);
        rd_exp("R5 write one does not set", 2'd0, 16'h0040);

        // R9 unused bits read zero
        wr(2'd0, 16'hFF3E);
        rd_exp("R9 control unused bits", 2'd0, 16'h0002);
        wr(2'd3, 16'hFFFE);
        rd_exp("R9 run unused bits", 2'd3, 16'h0000);

        // R6 clear and match collide: constant 0, every enable matches
        wr(2'd0, 16'h0040);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd0);
        wr(2'd3, 16'd1);
        wr_on_match(2'd0, 16'h0040);
        wr(2'd3, 16'd0);
        rd_exp("R6 set wins over clear", 2'd0, 16'h00C0);
        check("R6 irq", {15'd0, irq}, 16'd1);

        // R7 counter load on a match cycle
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd5);
        wr(2'd3, 16'd1);
        wr_on_match(2'd1, 16'h1234);
        wr(2'd3, 16'd0);
        rd_exp("R7 load wins", 2'd1, 16'h1234);
        rd_exp("R7 no flag", 2'd0, 16'h0000);

        // R10 wrap above the constant
        wr(2'd1, 16'hFFFE);
        wr(2'd3, 16'd1);
        repeat (11) @(posedge clk);
        wr(2'd3, 16'd0);
        rd_exp("R10 wrapped count", 2'd1, 16'h0001);
        rd_exp("R10 no flag", 2'd0, 16'h0000);

        // random mix, checked against the model (R2 R3 R4 R5 R9)
        for (int it = 0; it < 400; it++) begin
            automatic int op = $urandom_range(0, 5);
            case (op)
                0: wr(2'd0, 16'($urandom()));
                1: wr(2'd1, 16'($urandom_range(0, 40)));
                2: wr(2'd2, 16'($urandom_range(0, 30)));
                3: wr(2'd3, 16'($urandom_range(0, 1)));
                4: wr(2'd0, {8'd0, 1'b0, 1'($urandom), 6'($urandom)});
                default: repeat ($urandom_range(1, 60)) @(posedge clk);
            endcase
            if (it % 4 == 0) check_all("R9 random readback");
        end
        check_all("R4 final readback");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule